// File: doc/BRIEF.md
# Key-Guarded Watchdog and Interval Timer

This block counts tick strobes from one of four clock-enable inputs in a free-running 32-bit counter. A 3-bit field in a 16-bit control register picks one of eight counter bits as the expiry tap. The block expires when that bit goes from 0 to 1. In watchdog mode, expiry drives a one-cycle reset pulse. After the pulse, the control register is back at its reset value and the counter is zero. In interval mode, expiry sets a sticky interrupt flag instead, and the counter keeps running.

Software writes the control register through a simple synchronous write port. A write takes effect only when its upper byte carries the write key. Any other upper byte is treated as a fault and causes a reset pulse. A read shows a separate fixed read key in the upper byte. The lower byte holds the stored settings: a hold bit, a source select, a mode bit, a self-clearing counter-clear bit and the interval select.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, `rd_data_o` reads 0x6900 (read key 0x69 in bits 15:8, all setting bits 0), and `wdt_rst_o` and `irq_o` are low.
- R2: Bits 2:0 select the tap bit. The encodings 0..7 map to counter bits 31, 27, 23, 19, 15, 13, 9 and 6. Starting from a cleared counter, expiry occurs on the 2^tap-th selected tick, which is when the tap bit rises.
- R3: Writing bit 3 as 1 zeroes the counter, and writing it as 0 does nothing. Bit 3 always reads as 0.
- R4: Bits 15:8 of `rd_data_o` always read as the read key 0x69.
- R5: Bits 6:5 choose which bit of `tick_i` advances the counter (0 to 3 select `tick_i[0]` to `tick_i[3]`). Strobes on the other three inputs do not advance it.
- R6: While bit 7 (hold) is 1, the counter does not advance and no expiry occurs.
- R7: In watchdog mode (bit 4 = 0), expiry makes `wdt_rst_o` high for exactly the cycle after the expiring tick. At that same edge, the register returns to its reset value and the counter is cleared.
- R8: A write is accepted only when `wr_data_i[15:8]` is 0x5A. A write with any other key does not load its data, pulses `wdt_rst_o` in the next cycle, and resets the register.
- R9: In interval mode (bit 4 = 1), expiry sets `irq_o` in the next cycle and gives no reset pulse. `irq_o` stays set until `irq_clr_i` is applied, and the counter keeps running. A reset pulse also clears `irq_o`.
- R10: An accepted write that changes the interval select or the source select also clears the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 16 | Write data, key in bits 15:8 |
| rd_data_o | output | 16 | Read key and stored settings |
| tick_i | input | 4 | Count enable strobes, one per source |
| irq_clr_i | input | 1 | Clears the interval interrupt flag |
| wdt_rst_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Sticky interval interrupt flag |

## Verification
A counter that is off by even one count moves the reset or interrupt edge by one tick. The sweep therefore places the final tick exactly and checks that the output is silent one tick earlier. A register left in a wrong state after a pulse shows on `rd_data_o` in the very next cycle. A clear that fails to act, whether from the clear bit or from a select change, shows as an early expiry within one tap period. The bench also arranges a tap bit that is already set, so a missed clear surfaces as an expiry at a different tick count.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

   // Stored control byte, bit 7 down to bit 0.
   typedef struct packed {
      logic       hold;
      logic [1:0] src;
      logic       ivl_mode;
      logic       zap;
      logic [2:0] span;
   } wdt_cfg_t;

   localparam int unsigned NUM_SRC = 4;

   function automatic int unsigned span_to_bit(input logic [2:0] s);
      int unsigned b;
      case (s)
         3'd0: b = 31;
         3'd1: b = 27;
         3'd2: b = 23;
         3'd3: b = 19;
         3'd4: b = 15;
         3'd5: b = 13;
         3'd6: b = 9;
         default: b = 6;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/keyed_wdt_cfg.sv
module keyed_wdt_cfg
   import keyed_wdt_pkg::*;
#(
   parameter logic [7:0] WR_KEY = 8'h5A
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       wr_en_i,
   input  logic [15:0] wr_data_i,
   input  logic       fire_i,
   output wdt_cfg_t   cfg_q,
   output logic       wr_bad_o,
   output logic       cnt_zap_o
);

   wdt_cfg_t wr_cfg;
   logic     wr_ok;

   assign wr_cfg    = wdt_cfg_t'(wr_data_i[7:0]);
   assign wr_ok     = wr_en_i && (wr_data_i[15:8] == WR_KEY);
   assign wr_bad_o  = wr_en_i && (wr_data_i[15:8] != WR_KEY);
   assign cnt_zap_o = wr_ok && (wr_cfg.zap ||
                                (wr_cfg.span != cfg_q.span) ||
                                (wr_cfg.src  != cfg_q.src));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else if (fire_i) begin
         cfg_q <= '0;
      end else if (wr_ok) begin
         cfg_q     <= wr_cfg;
         cfg_q.zap <= 1'b0;
      end
   end

   p_zap_never_stored_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q.zap == 1'b0);

endmodule

// File: rtl/keyed_wdt_count.sv
module keyed_wdt_count
   import keyed_wdt_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [NUM_SRC-1:0]     tick_i,
   input  logic [1:0]             src_i,
   input  logic                   hold_i,
   input  logic [2:0]             span_i,
   input  logic                   clr_i,
   output logic                   rise_o
);

   localparam int unsigned TAP_W = $clog2(CNT_W);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;
   logic [TAP_W-1:0] tap;
   logic             adv;

   assign tap    = TAP_W'(span_to_bit(span_i));
   assign adv    = tick_i[src_i] && !hold_i;
   assign cnt_nx = cnt_q + CNT_W'(1);
   assign rise_o = adv && cnt_nx[tap] && !cnt_q[tap];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_nx;
      end
   end

   p_hold_frozen_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hold_i && !clr_i) |=> (cnt_q == $past(cnt_q)));

   p_other_src_idle_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i[src_i] && !clr_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/keyed_wdt_out.sv
module keyed_wdt_out (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rise_i,
   input  logic ivl_mode_i,
   input  logic wr_bad_i,
   input  logic irq_clr_i,
   output logic fire_o,
   output logic rst_q,
   output logic irq_q
);

   assign fire_o = wr_bad_i || (rise_i && !ivl_mode_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rst_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         rst_q <= fire_o;
         if (fire_o)                     irq_q <= 1'b0;
         else if (rise_i && ivl_mode_i)  irq_q <= 1'b1;
         else if (irq_clr_i)             irq_q <= 1'b0;
      end
   end

   p_irq_sticky_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q && !irq_clr_i && !fire_o) |=> irq_q);

   p_irq_only_interval_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_q) |-> $past(ivl_mode_i));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import keyed_wdt_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter logic [7:0]  WR_KEY   = 8'h5A,
   parameter logic [7:0]  RD_KEY   = 8'h69,
   parameter bit          REG_READ = 1'b0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        wr_en_i,
   input  logic [15:0] wr_data_i,
   output logic [15:0] rd_data_o,
   input  logic [3:0]  tick_i,
   input  logic        irq_clr_i,
   output logic        wdt_rst_o,
   output logic        irq_o
);

   if (CNT_W < 32) begin : g_bad_width
      $error("keyed_wdt: CNT_W must cover tap bit 31");
   end
   if (WR_KEY == RD_KEY) begin : g_bad_keys
      $error("keyed_wdt: write and read keys must differ");
   end

   wdt_cfg_t cfg_q;
   logic     wr_bad;
   logic     cnt_zap;
   logic     fire;
   logic     rise_raw;
   logic     rise;
   logic [15:0] rd_view;

   keyed_wdt_cfg #(.WR_KEY(WR_KEY)) u_cfg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_data_i(wr_data_i),
      .fire_i   (fire),
      .cfg_q    (cfg_q),
      .wr_bad_o (wr_bad),
      .cnt_zap_o(cnt_zap)
   );

   keyed_wdt_count #(.CNT_W(CNT_W)) u_count (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .src_i (cfg_q.src),
      .hold_i(cfg_q.hold),
      .span_i(cfg_q.span),
      .clr_i (cnt_zap || fire),
      .rise_o(rise_raw)
   );

   assign rise = rise_raw && !cnt_zap;

   keyed_wdt_out u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rise_i    (rise),
      .ivl_mode_i(cfg_q.ivl_mode),
      .wr_bad_i  (wr_bad),
      .irq_clr_i (irq_clr_i),
      .fire_o    (fire),
      .rst_q     (wdt_rst_o),
      .irq_q     (irq_o)
   );

   assign rd_view = {RD_KEY, cfg_q.hold, cfg_q.src, cfg_q.ivl_mode, 1'b0, cfg_q.span};

   if (REG_READ) begin : g_rd_reg
      logic [15:0] rd_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) rd_q <= {RD_KEY, 8'h00};
         else         rd_q <= rd_view;
      end
      assign rd_data_o = rd_q;
   end else begin : g_rd_comb
      assign rd_data_o = rd_view;
   end

   p_bad_key_pulse_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && (wr_data_i[15:8] != WR_KEY)) |=> wdt_rst_o);

   p_read_key_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[15:8] == RD_KEY);

   p_clr_reads_zero_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[3] == 1'b0);

endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;

   localparam int CLK_P = 10;
   localparam logic [15:0] K = 16'h5A00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [3:0]  tick = '0;
   logic        irq_clr = 1'b0;
   logic        wdt_rst;
   logic        irq;

   int vec = 0;
   int bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   keyed_wdt u_dut (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .wr_en_i  (wr_en),
      .wr_data_i(wr_data),
      .rd_data_o(rd_data),
      .tick_i   (tick),
      .irq_clr_i(irq_clr),
      .wdt_rst_o(wdt_rst),
      .irq_o    (irq)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive inputs at a falling edge, let one rising edge pass, return at the next falling edge.
   task automatic cyc(input logic [3:0] m, input logic w, input logic [15:0] d, input logic c);
      tick = m; wr_en = w; wr_data = d; irq_clr = c;
      @(negedge clk);
      tick = '0; wr_en = 1'b0; wr_data = '0; irq_clr = 1'b0;
   endtask

   task automatic ticks(input logic [3:0] m, input int n);
      for (int i = 0; i < n; i++) begin
         cyc(m, 1'b0, 16'h0, 1'b0);
         if (wdt_rst) pulses++;
      end
   endtask

   task automatic wr(input logic [15:0] d);
      cyc(4'h0, 1'b1, d, 1'b0);
   endtask

   task automatic expiry(input int sel, input int src, input int tapb);
      logic [3:0] m;
      m = 4'(1 << src);
      wr(K | 16'h0008 | 16'(src << 5) | 16'(sel));
      pulses = 0;
      ticks(~m, 50);
      chk(pulses == 0, "R5 other sources", pulses, 0);
      ticks(m, (1 << tapb) - 1);
      chk(pulses == 0, "R2 early expiry", pulses, 0);
      cyc(m, 1'b0, 16'h0, 1'b0);
      chk(wdt_rst == 1'b1, "R2 R7 expiry pulse", int'(wdt_rst), 1);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);
      chk(wdt_rst == 1'b0, "R7 single pulse", int'(wdt_rst), 0);
      chk(rd_data == 16'h6900, "R7 reg reset", int'(rd_data), 16'h6900);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R4 reset state
      chk(rd_data == 16'h6900, "R1 reset read", int'(rd_data), 16'h6900);
      chk(wdt_rst == 1'b0 && irq == 1'b0, "R1 outputs low", int'({wdt_rst, irq}), 0);

      // R2 R5 R7 sweep: taps 6 and 9 on every source, then taps 13 and 15
      for (int s = 0; s < 4; s++) expiry(7, s, 6);
      for (int s = 0; s < 4; s++) expiry(6, s, 9);
      expiry(5, 2, 13);
      expiry(4, 3, 15);

      // R8 accepted and rejected keys
      wr(K | 16'h0097);
      chk(rd_data == 16'h6997, "R8 good key loads", int'(rd_data), 16'h6997);
      wr(16'h3312);
      chk(wdt_rst == 1'b1, "R8 bad key pulse", int'(wdt_rst), 1);
      chk(rd_data == 16'h6900, "R8 bad key no load", int'(rd_data), 16'h6900);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);
      wr(16'h6955);
      chk(wdt_rst == 1'b1 && rd_data == 16'h6900, "R8 read key rejected",
          int'(rd_data), 16'h6900);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);

      // R3 clear bit
      wr(K | 16'h000F);
      chk(rd_data == 16'h6907, "R3 clear reads 0", int'(rd_data), 16'h6907);
      pulses = 0;
      ticks(4'h1, 40);
      wr(K | 16'h000F);
      ticks(4'h1, 63);
      chk(pulses == 0, "R3 counter zeroed", pulses, 0);
      cyc(4'h1, 1'b0, 16'h0, 1'b0);
      chk(wdt_rst == 1'b1, "R3 expiry after clear", int'(wdt_rst), 1);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);

      // R6 hold
      wr(K | 16'h008F);
      pulses = 0;
      ticks(4'h1, 200);
      chk(pulses == 0, "R6 hold blocks expiry", pulses, 0);
      wr(K | 16'h0007);
      ticks(4'h1, 63);
      chk(pulses == 0, "R6 count frozen at zero", pulses, 0);
      cyc(4'h1, 1'b0, 16'h0, 1'b0);
      chk(wdt_rst == 1'b1, "R6 expiry after release", int'(wdt_rst), 1);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);

      // R10 select change clears a count whose bit 6 is already set
      wr(K | 16'h000E);
      pulses = 0;
      ticks(4'h1, 100);
      wr(K | 16'h0007);
      ticks(4'h1, 63);
      chk(pulses == 0, "R10 select change clears", pulses, 0);
      cyc(4'h1, 1'b0, 16'h0, 1'b0);
      chk(wdt_rst == 1'b1, "R10 full period after change", int'(wdt_rst), 1);
      cyc(4'h0, 1'b0, 16'h0, 1'b0);

      // R9 interval mode
      wr(K | 16'h001F);
      chk(rd_data == 16'h6917, "R9 mode stored", int'(rd_data), 16'h6917);
      pulses = 0;
      ticks(4'h1, 63);
      chk(irq == 1'b0, "R9 no early irq", int'(irq), 0);
      cyc(4'h1, 1'b0, 16'h0, 1'b0);
      chk(irq == 1'b1 && wdt_rst == 1'b0, "R9 irq on expiry", int'({irq, wdt_rst}), 2);
      ticks(4'h1, 10);
      chk(irq == 1'b1 && pulses == 0, "R9 irq sticky, no reset", int'(irq), 1);
      cyc(4'h0, 1'b0, 16'h0, 1'b1);
      chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
      ticks(4'h1, 117);
      chk(irq == 1'b0, "R9 counter keeps running", int'(irq), 0);
      cyc(4'h1, 1'b0, 16'h0, 1'b0);
      chk(irq == 1'b1, "R9 next rise of tap", int'(irq), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   end

endmodule